// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block is the transfer engine that sits behind a DMA controller's register file. It serves four channels. Each channel keeps a base and a current 16-bit address, a base and a current 16-bit count, an 8-bit page, a mode and a mask bit. When an unmasked channel requests service, the sequencer raises a hold request. Once hold is acknowledged, it runs exactly one single-mode transfer cycle. During that cycle it drives a 24-bit physical address, pulses the channel acknowledge together with a memory strobe, and then steps the address up and the count down.

At terminal count the sequencer pulses a completion output and latches a per-channel status flag. It then either masks the channel or reloads it from the base registers. A channel in cascade mode is only passed through: its request becomes the hold request, and hold acknowledge comes back as its acknowledge. The parameter `WORD_MODE` picks byte channels (64K pages) or word channels (128K pages, with the address shifted left by one). In both cases the address counter wraps inside its page and never carries into the page.

Top module: `dmaseq_top`

## Requirements
- R1: With `WORD_MODE=0`, each transfer drives `phys_addr = {page[7:0], cur_addr[15:0]}`.
- R2: With `WORD_MODE=1`, each transfer drives `phys_addr = {page[7:1], cur_addr[15:0], 1'b0}`. Page bit 0 has no effect and byte address bit 0 is always 0.
- R3: After every transfer the current address increments modulo 2^16, and the page is never changed. A run that starts at 0xFFFE therefore goes 0xFFFE, 0xFFFF, 0x0000, 0x0001 in the same page.
- R4: A channel programmed with count N performs N+1 transfers. `tc` is high only during the transfer that starts with the current count at 0x0000.
- R5: Without auto-initialise, terminal count sets the channel's mask bit. The channel's request is then ignored: `hrq` stays low.
- R6: With auto-initialise, terminal count reloads the current address and count from the base values and leaves the channel unmasked.
- R7: Among channels whose request is high and whose mask bit is clear, the lowest-numbered channel is served. Masked channels are never served.
- R8: A transfer raises `hrq` one cycle after the winning request is seen, and pulses the one-hot `dack` for exactly one cycle after `hlda` is seen. Mode type 01 (device to memory) pulses `mem_wr`, type 10 (memory to device) pulses `mem_rd`, and type 00 (verify) pulses neither.
- R9: For a cascade-mode channel, `hrq` follows that channel's request, `dack` of that channel follows `hlda`, and no strobe, address or count activity occurs. `hrq` falls in the same cycle the request drops.
- R10: `stat_q[3:0]` latches terminal count per channel and clears on the clock edge that samples `stat_rd`. `stat_q[7:4]` shows the live request lines.
- R11: After reset, `hrq`, `dack`, the strobes and `stat_q[3:0]` are zero, and all four channels are masked.
- R12: The configuration write selects a channel with `cfg_ch` and a field with `cfg_sel`: 0 loads the base and current address, 1 loads the base and current count, 2 loads the page from data[7:0], 3 loads the mode from data[3:0] (bit 3 cascade, bit 2 auto-initialise, bits 1:0 transfer type), and 4 writes the mask bit from data[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_sel | input | 3 | Field selected for the write |
| cfg_wdata | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the terminal-count flags |
| stat_q | output | 8 | {live requests, terminal-count flags} |
| dreq | input | 4 | Device request per channel |
| hrq | output | 1 | Hold request to the bus owner |
| hlda | input | 1 | Hold acknowledge from the bus owner |
| dack | output | 4 | Device acknowledge per channel |
| phys_addr | output | 24 | Physical address during a transfer, zero otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal-count pulse on the final transfer |

## Verification
The bench starts channels at 0xFFFE so that the address crosses the 16-bit boundary; a design that carried into the page would emit a different page byte on the third transfer. It drives a byte-mode and a word-mode instance with the same stimulus and sweeps odd and even pages, so that a word-mode former that kept page bit 0 or dropped the shift is caught on every transfer. It counts transfers and `tc` pulses per channel: an off-by-one count gives N or N+2 transfers, and a lost mask or a missed reload shows up as extra transfers or as addresses that do not return to the base. Competing requests, a masked requester and a cascade channel test the priority order and the pass-through, where a wrong design would serve out of order or emit strobes.

// File: rtl/dmaseq_pkg.sv
// Package: shared types and field codes for the DMA transfer sequencer.
// Assumes: a four-bit mode field per channel; field select codes are fixed.
package dmaseq_pkg;

    // Sequencer states: wait, bus request, one transfer, cascade pass-through
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2,
        ST_CASC = 2'd3
    } seq_state_t;

    // Per-channel mode field, MSB first
    typedef struct packed {
        logic       cascade;
        logic       autoinit;
        logic [1:0] xtype;
    } chan_mode_t;

    // Configuration field select codes
    localparam logic [2:0] SEL_ADDR = 3'd0;
    localparam logic [2:0] SEL_CNT  = 3'd1;
    localparam logic [2:0] SEL_PAGE = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_MASK = 3'd4;

    // Transfer type codes
    localparam logic [1:0] XT_VERIFY = 2'b00;
    localparam logic [1:0] XT_TO_MEM = 2'b01;
    localparam logic [1:0] XT_FR_MEM = 2'b10;

endpackage

// File: rtl/dmaseq_chan.sv
// Module: one channel's register set and counters.
// Holds base/current address and count, page, mode and mask. Steps once per
// transfer; at terminal count it reloads (auto-initialise) or masks itself.
// Assumes: PW <= AW so the page fits in the write data; reset masks the channel.
module dmaseq_chan
    import dmaseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output chan_mode_t    mode,
    output logic          masked,
    output logic          at_term
);

    logic [AW-1:0] base_addr;
    logic [AW-1:0] base_cnt;

    // Terminal count is the transfer that starts from an all-zero count
    assign at_term = (cur_cnt == '0);

    // Register writes take precedence; otherwise advance on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            page      <= '0;
            mode      <= '0;
            masked    <= 1'b1;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR: begin
                    base_addr <= wr_data;
                    cur_addr  <= wr_data;
                end
                SEL_CNT: begin
                    base_cnt <= wr_data;
                    cur_cnt  <= wr_data;
                end
                SEL_PAGE: page   <= wr_data[PW-1:0];
                SEL_MODE: mode   <= chan_mode_t'(wr_data[3:0]);
                SEL_MASK: masked <= wr_data[0];
                default: ;
            endcase
        end else if (step) begin
            if (at_term && mode.autoinit) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
                if (at_term) begin
                    masked <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dmaseq_arb.sv
// Module: fixed-priority picker over the eligible channels.
// Index 0 wins over every higher index. Assumes NCH >= 2.
module dmaseq_arb #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] eligible,
    output logic           found,
    output logic [CW-1:0]  win
);

    // Scan from the lowest priority upward so the lowest index is kept last
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                win   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/dmaseq_addr.sv
// Module: physical address former.
// Byte channels concatenate page and address (64K pages). Word channels drop
// page bit 0 and shift the address left by one (128K pages, even addresses).
module dmaseq_addr #(
    parameter int AW        = 16,
    parameter int PW        = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHW      = AW + PW
) (
    input  logic [PW-1:0]  page,
    input  logic [AW-1:0]  addr,
    output logic [PHW-1:0] phys
);

    generate
        if (WORD_MODE) begin : g_word
            // Word addressing: page bit 0 is replaced by the shifted address
            assign phys = {page[PW-1:1], addr, 1'b0};
        end else begin : g_byte
            // Byte addressing: page sits directly above the address
            assign phys = {page, addr};
        end
    endgenerate

endmodule

// File: rtl/dmaseq_top.sv
// Module: DMA transfer sequencer, top level.
// Arbitrates four channels, runs one single-mode transfer per bus grant,
// passes cascade channels through, and keeps terminal-count status.
// Assumes: a requester holds dreq until served; hlda answers hrq.
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int AW        = 16,
    parameter int PW        = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int CW       = $clog2(NCH),
    localparam int PHW      = AW + PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CW-1:0]    cfg_ch,
    input  logic [2:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             stat_rd,
    output logic [2*NCH-1:0] stat_q,
    input  logic [NCH-1:0]   dreq,
    output logic             hrq,
    input  logic             hlda,
    output logic [NCH-1:0]   dack,
    output logic [PHW-1:0]   phys_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             tc
);

    logic [AW-1:0] ch_addr [NCH];
    logic [AW-1:0] ch_cnt  [NCH];
    logic [PW-1:0] ch_page [NCH];
    chan_mode_t    ch_mode [NCH];
    logic [NCH-1:0] ch_masked;
    logic [NCH-1:0] ch_term;
    logic [NCH-1:0] ch_step;
    logic [NCH-1:0] ch_wr;
    logic [NCH-1:0] tc_flag;

    seq_state_t    state, state_nx;
    logic [CW-1:0] cur_ch, cur_ch_nx;
    logic          arb_found;
    logic [CW-1:0] arb_win;
    logic          in_xfer;
    logic [PHW-1:0] phys_raw;

    // Channel register sets, one per channel
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign ch_wr[g]   = cfg_we && (cfg_ch == CW'(g));
            assign ch_step[g] = in_xfer && (cur_ch == CW'(g));
            dmaseq_chan #(.AW(AW), .PW(PW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ch_wr[g]),
                .wr_sel   (cfg_sel),
                .wr_data  (cfg_wdata),
                .step     (ch_step[g]),
                .cur_addr (ch_addr[g]),
                .cur_cnt  (ch_cnt[g]),
                .page     (ch_page[g]),
                .mode     (ch_mode[g]),
                .masked   (ch_masked[g]),
                .at_term  (ch_term[g])
            );
        end
    endgenerate

    // Priority pick among unmasked requesters
    dmaseq_arb #(.NCH(NCH)) u_arb (
        .eligible (dreq & ~ch_masked),
        .found    (arb_found),
        .win      (arb_win)
    );

    // Address former for the channel being served
    dmaseq_addr #(.AW(AW), .PW(PW), .WORD_MODE(WORD_MODE)) u_addr (
        .page (ch_page[cur_ch]),
        .addr (ch_addr[cur_ch]),
        .phys (phys_raw)
    );

    assign in_xfer = (state == ST_XFER);

    // Next-state and channel-latch decision
    always_comb begin
        state_nx  = state;
        cur_ch_nx = cur_ch;
        case (state)
            ST_IDLE: begin
                if (arb_found) begin
                    cur_ch_nx = arb_win;
                    state_nx  = ch_mode[arb_win].cascade ? ST_CASC : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!dreq[cur_ch] || ch_masked[cur_ch]) begin
                    state_nx = ST_IDLE;
                end else if (hlda) begin
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: state_nx = ST_IDLE;
            ST_CASC: begin
                if (!dreq[cur_ch]) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and served-channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            state  <= state_nx;
            cur_ch <= cur_ch_nx;
        end
    end

    // Bus request and acknowledge outputs
    always_comb begin
        dack = '0;
        hrq  = 1'b0;
        case (state)
            ST_HOLD: hrq = 1'b1;
            ST_XFER: begin
                hrq          = 1'b1;
                dack[cur_ch] = 1'b1;
            end
            ST_CASC: begin
                hrq          = dreq[cur_ch];
                dack[cur_ch] = hlda && dreq[cur_ch];
            end
            default: ;
        endcase
    end

    // Transfer-cycle outputs: address, strobes by type, terminal pulse
    always_comb begin
        phys_addr = in_xfer ? phys_raw : '0;
        mem_wr    = in_xfer && (ch_mode[cur_ch].xtype == XT_TO_MEM);
        mem_rd    = in_xfer && (ch_mode[cur_ch].xtype == XT_FR_MEM);
        tc        = in_xfer && ch_term[cur_ch];
    end

    // Terminal-count flags: set on the final transfer, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_flag <= '0;
        end else begin
            tc_flag <= (stat_rd ? '0 : tc_flag) | (ch_step & ch_term);
        end
    end

    assign stat_q = {dreq, tc_flag};

endmodule

// File: rtl/dmaseq_chk.sv
// Module: protocol checker for dmaseq_top, attached by bind.
// Watches only the top-level ports.
module dmaseq_chk #(
    parameter int NCH       = 4,
    parameter int PHW       = 24,
    parameter bit WORD_MODE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_rd,
    input logic [2*NCH-1:0] stat_q,
    input logic [NCH-1:0]   dack,
    input logic             hrq,
    input logic [PHW-1:0]   phys_addr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             tc
);

    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));                                              // R8
    AST_DACK_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hrq);                                             // R8
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                         // R8
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));                  // R8
    AST_TC_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (|dack));                                              // R4
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);                                                  // R4
    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && WORD_MODE) |-> !phys_addr[0]);         // R2
    AST_STAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (stat_q[NCH-1:0] != '0));                              // R10
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tc) |=> (stat_q[NCH-1:0] == '0));                // R10

endmodule

bind dmaseq_top dmaseq_chk #(.NCH(NCH), .PHW(PHW), .WORD_MODE(WORD_MODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .stat_q    (stat_q),
    .dack      (dack),
    .hrq       (hrq),
    .phys_addr (phys_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .tc        (tc)
);

// File: tb/sim_dmaseq_top.sv
// Bench: byte-mode instance u0 and word-mode instance u1 share all stimulus.
// A negedge monitor keeps an arithmetic model of every channel and checks each
// transfer against it; directed sequences cover reset, wrap, reload, priority,
// cascade and status.
module sim_dmaseq_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [3:0]  dreq = '0;

    logic        hrq0, hrq1, rd0, rd1, wr0, wr1, tc0, tc1;
    logic [3:0]  dack0, dack1;
    logic [23:0] pa0, pa1;
    logic [7:0]  st0, st1;

    int checks = 0;
    int errors = 0;

    // Model state per channel
    int e_addr [4];
    int e_cnt  [4];
    int e_ba   [4];
    int e_bc   [4];
    int e_page [4];
    int e_mode [4];
    int e_mask [4];
    int nx = 0;
    int ntc = 0;
    int nx_ch [4];

    always #(PERIOD/2) clk = ~clk;

    dmaseq_top #(.WORD_MODE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
        .stat_q(st0), .dreq(dreq), .hrq(hrq0), .hlda(hrq0), .dack(dack0),
        .phys_addr(pa0), .mem_rd(rd0), .mem_wr(wr0), .tc(tc0)
    );

    dmaseq_top #(.WORD_MODE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
        .stat_q(st1), .dreq(dreq), .hrq(hrq1), .hlda(hrq1), .dack(dack1),
        .phys_addr(pa1), .mem_rd(rd1), .mem_wr(wr1), .tc(tc1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // R12: configuration write plus the matching model update
    task automatic cfg(input int ch, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = 16'(data);
        case (sel)
            0: begin e_ba[ch] = data & 16'hFFFF; e_addr[ch] = data & 16'hFFFF; end
            1: begin e_bc[ch] = data & 16'hFFFF; e_cnt[ch] = data & 16'hFFFF; end
            2: e_page[ch] = data & 8'hFF;
            3: e_mode[ch] = data & 4'hF;
            4: e_mask[ch] = data & 1;
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_xfers(input int target);
        int guard = 0;
        do begin
            @(negedge clk); #1;
            guard++;
        end while (nx < target && guard < 5000);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Transfer monitor: every non-cascade dack is checked against the model
    always @(negedge clk) begin
        int ch, win, elig, exp0, exp1, pg;
        if (rst_n && (dack0 != 0) && !e_mode[dack0[0] ? 0 : dack0[1] ? 1 : dack0[2] ? 2 : 3][3]) begin
            ch = dack0[0] ? 0 : dack0[1] ? 1 : dack0[2] ? 2 : 3;
            elig = 0;
            for (int i = 0; i < 4; i++) if (dreq[i] && !e_mask[i]) elig |= (1 << i);
            win = 4;
            for (int i = 3; i >= 0; i--) if (elig[i]) win = i;
            chk(ch == win, "R7", "served channel", ch, win);
            chk($countones(dack0) == 1, "R8", "dack one-hot", dack0, 1 << ch);
            chk(dack1 == dack0, "R8", "word instance dack", dack1, dack0);
            pg = e_page[ch];
            exp0 = (pg << 16) | e_addr[ch];
            exp1 = ((pg >> 1) << 17) | (e_addr[ch] << 1);
            chk(pa0 == 24'(exp0), "R1 R3", "byte phys_addr", pa0, exp0);
            chk(pa1 == 24'(exp1), "R2 R3", "word phys_addr", pa1, exp1);
            chk(wr0 == ((e_mode[ch] & 3) == 1), "R8", "mem_wr", wr0, (e_mode[ch] & 3) == 1);
            chk(rd0 == ((e_mode[ch] & 3) == 2), "R8", "mem_rd", rd0, (e_mode[ch] & 3) == 2);
            chk(tc0 == (e_cnt[ch] == 0), "R4", "tc pulse", tc0, e_cnt[ch] == 0);
            if (tc0) ntc++;
            if (e_cnt[ch] == 0 && e_mode[ch][2]) begin
                e_addr[ch] = e_ba[ch];
                e_cnt[ch]  = e_bc[ch];
            end else begin
                if (e_cnt[ch] == 0) e_mask[ch] = 1;
                e_addr[ch] = (e_addr[ch] + 1) & 16'hFFFF;
                e_cnt[ch]  = (e_cnt[ch] - 1) & 16'hFFFF;
            end
            nx++;
            nx_ch[ch]++;
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, tcb, c0, c2, c3;
        for (int i = 0; i < 4; i++) begin
            e_addr[i] = 0; e_cnt[i] = 0; e_ba[i] = 0; e_bc[i] = 0;
            e_page[i] = 0; e_mode[i] = 0; e_mask[i] = 1; nx_ch[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk(hrq0 == 0 && dack0 == 0, "R11", "hrq/dack after reset", {hrq0, dack0}, 0);
        chk(rd0 == 0 && wr0 == 0 && tc0 == 0, "R11", "strobes after reset", {rd0, wr0, tc0}, 0);
        chk(st0 == 0, "R11", "status after reset", st0, 0);
        dreq = 4'hF;
        idle(6);
        chk(hrq0 == 0, "R11", "all channels masked after reset", hrq0, 0);
        chk(st0[7:4] == 4'hF, "R10", "live request bits", st0[7:4], 4'hF);
        dreq = 4'h0;

        // Channel 1: wrap across 0xFFFF, count 3, no auto-initialise
        cfg(1, 0, 16'hFFFE);
        cfg(1, 1, 3);
        cfg(1, 2, 8'h35);
        cfg(1, 3, 4'b0001);
        cfg(1, 4, 0);
        base = nx; tcb = ntc;
        dreq = 4'b0010;
        @(negedge clk);
        chk(hrq0 == 1 && dack0 == 0, "R8", "hrq one cycle after request", {hrq0, dack0}, 5'b10000);
        @(negedge clk);
        chk(dack0 == 4'b0010 && wr0 == 1, "R8", "dack one cycle after hlda", {dack0, wr0}, 5'b00101);
        wait_xfers(base + 4);
        idle(12);
        chk(nx - base == 4, "R4", "transfers for count 3", nx - base, 4);
        chk(ntc - tcb == 1, "R4", "single tc pulse", ntc - tcb, 1);
        chk(hrq0 == 0, "R5", "masked after terminal count", hrq0, 0);
        chk(st0 == 8'h22, "R10", "status after terminal count", st0, 8'h22);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk(st0[3:0] == 0, "R10", "flags cleared by read", st0[3:0], 0);
        dreq = 4'h0;

        // Channel 2: auto-initialise, count 1, memory to device
        cfg(2, 0, 16'h1000);
        cfg(2, 1, 1);
        cfg(2, 2, 8'h80);
        cfg(2, 3, 4'b0110);
        cfg(2, 4, 0);
        base = nx; tcb = ntc;
        dreq = 4'b0100;
        wait_xfers(base + 7);
        @(posedge clk); #1;
        dreq = 4'h0;
        idle(8);
        chk(nx - base == 7, "R6", "auto-init keeps channel serving", nx - base, 7);
        chk(ntc - tcb == 3, "R6", "tc on every reload", ntc - tcb, 3);
        chk(st0[2] == 1, "R10", "channel 2 flag", st0[2], 1);

        // Priority: channels 0 and 3 compete, channel 2 masked while requesting
        cfg(2, 4, 1);
        cfg(0, 0, 16'h0010);
        cfg(0, 1, 2);
        cfg(0, 2, 8'h01);
        cfg(0, 3, 4'b0001);
        cfg(0, 4, 0);
        cfg(3, 0, 16'h0200);
        cfg(3, 1, 1);
        cfg(3, 2, 8'hFE);
        cfg(3, 3, 4'b0000);
        cfg(3, 4, 0);
        c0 = nx_ch[0]; c2 = nx_ch[2]; c3 = nx_ch[3];
        dreq = 4'b1101;
        wait_xfers(nx + 5);
        idle(12);
        chk(nx_ch[0] - c0 == 3, "R7", "channel 0 transfers", nx_ch[0] - c0, 3);
        chk(nx_ch[3] - c3 == 2, "R7", "channel 3 transfers", nx_ch[3] - c3, 2);
        chk(nx_ch[2] - c2 == 0, "R7", "masked channel 2 ignored", nx_ch[2] - c2, 0);
        chk(hrq0 == 0, "R5", "both channels masked at end", hrq0, 0);
        dreq = 4'h0;

        // R9: cascade pass-through on channel 1
        cfg(1, 3, 4'b1000);
        cfg(1, 4, 0);
        base = nx;
        dreq = 4'b0010;
        @(negedge clk);
        chk(hrq0 == 1 && dack0 == 4'b0010, "R9", "cascade hrq/dack", {hrq0, dack0}, 5'b10010);
        idle(3);
        chk(rd0 == 0 && wr0 == 0 && pa0 == 0, "R9", "cascade no cycle", {rd0, wr0, pa0}, 0);
        dreq = 4'h0; #1;
        chk(hrq0 == 0 && dack0 == 0, "R9", "cascade release", {hrq0, dack0}, 0);
        idle(3);
        chk(nx == base, "R9", "no transfers during cascade", nx - base, 0);
        cfg(1, 4, 1);

        // Page/address sweep, single transfer each, byte and word formers
        for (int k = 0; k < 16; k++) begin
            cfg(0, 0, (k * 16'h1111) ^ 16'hA5C3);
            cfg(0, 1, 0);
            cfg(0, 2, (k * 17 + 1) & 8'hFF);
            cfg(0, 3, 4'b0010);
            cfg(0, 4, 0);
            base = nx;
            dreq = 4'b0001;
            wait_xfers(base + 1);
            @(posedge clk); #1;
            dreq = 4'h0;
            idle(4);
            chk(nx - base == 1, "R4", "count 0 gives one transfer", nx - base, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule